// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold Interrupts

This block sits between a host register interface and a serial bus engine and buffers bytes in both directions. The host writes bytes into a transmit FIFO that the engine drains. The engine writes received bytes into a receive FIFO that the host drains. Each FIFO has its own enable and its own programmable threshold. A packed status word reports the fill level, full and empty for both FIFOs.

Seven pending interrupt causes are kept in a write-one-to-clear status register:
- transmit below its threshold;
- receive at or above its threshold;
- an underrun and an overrun for each direction;
- a trailing-data timeout, for receive bytes that sit below the threshold with no traffic for a programmable number of cycles.

A mask register selects which pending causes drive the single interrupt line.

The host programs the block through a four-entry register select. The engine sees plain push/pop strobes. Read data for each FIFO is show-ahead: it is valid combinationally in the cycle the pop is asserted.

Top module: `dual_fifo_irq`

## Requirements
- R1: After reset the status word reads 0x01000100 (both FIFOs empty, levels 0, neither full), the pending status is 0, the interrupt line is low and both FIFOs are disabled.
- R2: Register select 0 is FIFO control: bit 0 enables receive, bit 1 enables transmit, bits 10:4 hold the receive threshold, bits 22:16 hold the transmit threshold. A disabled FIFO is emptied one cycle later. On a disabled FIFO, pushes and pops have no effect, a pop returns 0, and no flag is raised.
- R3: Each FIFO returns bytes in the order they were pushed. The status word gives the transmit level in bits 6:0 and the receive level in bits 22:16.
- R4: Status bit 7 is transmit full, bit 8 is transmit empty, bit 23 is receive full and bit 24 is receive empty. Full means the level equals the depth, and empty means the level is 0.
- R5: Pending bit 0 (transmit almost-empty) is set while transmit is enabled and its level is at or below the transmit threshold.
- R6: Pending bit 1 (receive almost-full) is set while receive is enabled and its level is at or above the receive threshold.
- R7: A push into a full enabled FIFO is dropped and leaves the level and contents unchanged. It sets pending bit 3 for transmit or bit 5 for receive.
- R8: A pop from an empty enabled FIFO returns 0 and sets pending bit 2 for transmit or bit 4 for receive.
- R9: Register select 3, bits 3:0, holds the trailing limit T. Pending bit 6 is set when the receive FIFO is enabled and holds between 1 and threshold-1 bytes, and T+1 clock edges have passed since the last receive push or pop with no push or pop in between.
- R10: Writing register select 2 clears each pending bit written as 1 and leaves bits written as 0. If a cause is active in the same cycle, its bit stays set.
- R11: Register select 1, bits 6:0, is the interrupt mask, with the same bit positions as the pending status. The interrupt line is high exactly when some pending bit has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 mask, 2 pending (W1C), 3 trailing limit |
| reg_wdata | input | 32 | Host register write data |
| host_tx_push | input | 1 | Host pushes a byte into the transmit FIFO |
| host_tx_data | input | 8 | Byte pushed by the host |
| host_rx_pop | input | 1 | Host pops a byte from the receive FIFO |
| host_rx_data | output | 8 | Head of the receive FIFO, 0 when empty or disabled |
| eng_tx_pop | input | 1 | Engine pops a byte from the transmit FIFO |
| eng_tx_data | output | 8 | Head of the transmit FIFO, 0 when empty or disabled |
| eng_rx_push | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Byte pushed by the engine |
| fifo_stat | output | 32 | Packed levels, full and empty flags |
| irq_stat | output | 7 | Pending interrupt causes |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with an 8-entry depth and keeps the 4-bit trailing limit. At that depth it can sweep every threshold against every fill level of both FIFOs, including the full and empty boundaries, and compare the almost-empty and almost-full bits to the arithmetic comparison at each point. With the trailing limit at 4 bits, every limit value from 0 to 15 gets its firing cycle checked exactly, plus a case where a mid-wait push restarts the count. Overrun, underrun, selective clearing and masking are then checked on the states left by the sweeps.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;

    localparam int LVL_FLD_W = 7;
    localparam int IRQ_W     = 7;

    typedef enum logic [1:0] {
        REG_CTL   = 2'd0,
        REG_MASK  = 2'd1,
        REG_PEND  = 2'd2,
        REG_TRAIL = 2'd3
    } reg_sel_e;

    // bit 0 is tx_ae (last member is the LSB)
    typedef struct packed {
        logic trail;
        logic rx_ovr;
        logic rx_und;
        logic tx_ovr;
        logic tx_und;
        logic rx_af;
        logic tx_ae;
    } irq_vec_t;

    typedef struct packed {
        logic [LVL_FLD_W-1:0] tx_trig;
        logic [LVL_FLD_W-1:0] rx_trig;
        logic                 tx_en;
        logic                 rx_en;
    } ctl_t;

    function automatic ctl_t ctl_from_word(input logic [31:0] w);
        ctl_t c;
        c.rx_en   = w[0];
        c.tx_en   = w[1];
        c.rx_trig = w[10:4];
        c.tx_trig = w[22:16];
        return c;
    endfunction

    function automatic logic [31:0] pack_status(
        input logic [LVL_FLD_W-1:0] tx_lvl,
        input logic                 tx_full,
        input logic                 tx_empty,
        input logic [LVL_FLD_W-1:0] rx_lvl,
        input logic                 rx_full,
        input logic                 rx_empty
    );
        logic [31:0] w;
        w        = '0;
        w[6:0]   = tx_lvl;
        w[7]     = tx_full;
        w[8]     = tx_empty;
        w[22:16] = rx_lvl;
        w[23]    = rx_full;
        w[24]    = rx_empty;
        return w;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            push,
    input  logic [DW-1:0]   wdata,
    input  logic            pop,
    output logic [DW-1:0]   rdata,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            empty,
    output logic            overrun,
    output logic            underrun
);
    logic [DW-1:0]   mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [LVLW-1:0] count;
    logic            do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full     = (count == LVLW'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = en && push && !full;
    assign do_pop   = en && pop && !empty;
    assign overrun  = en && push && full;
    assign underrun = en && pop && empty;
    assign rdata    = (en && !empty) ? mem[rd_ptr] : '0;
    assign level    = count;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + LVLW'(1);
                2'b01:   count <= count - LVLW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/trail_timer.sv
module trail_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          activity,
    input  logic [CW-1:0] limit,
    output logic          fire
);
    logic [CW-1:0] cnt;

    assign fire = arm && !activity && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !arm || activity) begin
            cnt <= '0;
        end else if (cnt != limit) begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
    import dfifo_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int TRAIL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             host_tx_push,
    input  logic [7:0]       host_tx_data,
    input  logic             host_rx_pop,
    output logic [7:0]       host_rx_data,
    input  logic             eng_tx_pop,
    output logic [7:0]       eng_tx_data,
    input  logic             eng_rx_push,
    input  logic [7:0]       eng_rx_data,
    output logic [31:0]      fifo_stat,
    output logic [IRQ_W-1:0] irq_stat,
    output logic             irq
);
    localparam int LVLW = $clog2(DEPTH + 1);

    ctl_t               ctl_q;
    irq_vec_t           mask_q, pend_q, evt;
    logic [TRAIL_W-1:0] trail_lim_q;
    logic [IRQ_W-1:0]   w1c;
    logic               unused_wdata;

    logic [LVLW-1:0]      tx_level, rx_level;
    logic [LVL_FLD_W-1:0] tx_lvl7, rx_lvl7;
    logic tx_full, tx_empty, tx_ovr, tx_und;
    logic rx_full, rx_empty, rx_ovr, rx_und;
    logic trail_arm, trail_fire;

    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q       <= '0;
            mask_q      <= '0;
            trail_lim_q <= '0;
        end else if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                REG_CTL:   ctl_q       <= ctl_from_word(reg_wdata);
                REG_MASK:  mask_q      <= irq_vec_t'(reg_wdata[IRQ_W-1:0]);
                REG_TRAIL: trail_lim_q <= reg_wdata[TRAIL_W-1:0];
                default:   ;
            endcase
        end
    end

    byte_fifo #(.DEPTH(DEPTH), .DW(8)) tx_fifo_i (
        .clk(clk), .rst(rst), .en(ctl_q.tx_en),
        .push(host_tx_push), .wdata(host_tx_data),
        .pop(eng_tx_pop), .rdata(eng_tx_data),
        .level(tx_level), .full(tx_full), .empty(tx_empty),
        .overrun(tx_ovr), .underrun(tx_und)
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(8)) rx_fifo_i (
        .clk(clk), .rst(rst), .en(ctl_q.rx_en),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(host_rx_pop), .rdata(host_rx_data),
        .level(rx_level), .full(rx_full), .empty(rx_empty),
        .overrun(rx_ovr), .underrun(rx_und)
    );

    // level fields are 7 bits wide; DEPTH is expected to stay below 128
    assign tx_lvl7 = LVL_FLD_W'(tx_level);
    assign rx_lvl7 = LVL_FLD_W'(rx_level);

    assign trail_arm = ctl_q.rx_en && (rx_lvl7 != '0) && (rx_lvl7 < ctl_q.rx_trig);

    trail_timer #(.CW(TRAIL_W)) trail_i (
        .clk(clk), .rst(rst), .arm(trail_arm),
        .activity(eng_rx_push || host_rx_pop),
        .limit(trail_lim_q), .fire(trail_fire)
    );

    always_comb begin
        evt        = '0;
        evt.tx_ae  = ctl_q.tx_en && (tx_lvl7 <= ctl_q.tx_trig);
        evt.rx_af  = ctl_q.rx_en && (rx_lvl7 >= ctl_q.rx_trig);
        evt.tx_und = tx_und;
        evt.tx_ovr = tx_ovr;
        evt.rx_und = rx_und;
        evt.rx_ovr = rx_ovr;
        evt.trail  = trail_fire;
    end

    assign w1c = (reg_we && reg_sel_e'(reg_sel) == REG_PEND) ? reg_wdata[IRQ_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= irq_vec_t'((pend_q & ~w1c) | evt);
    end

    assign fifo_stat = pack_status(tx_lvl7, tx_full, tx_empty, rx_lvl7, rx_full, rx_empty);
    assign irq_stat  = pend_q;
    assign irq       = |(pend_q & mask_q);

endmodule

// File: rtl/dfifo_chk.sv
module dfifo_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic        host_tx_push,
    input logic        host_rx_pop,
    input logic        eng_rx_push,
    input logic [7:0]  host_rx_data,
    input logic [31:0] fifo_stat,
    input logic [6:0]  irq_stat,
    input logic        irq,
    input logic        tx_en,
    input logic        rx_en
);
    AST_TX_LVL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_stat[6:0] <= 7'(DEPTH)); // R3

    AST_RX_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fifo_stat[23] && fifo_stat[24])); // R4

    AST_TX_OVR_FLAG: assert property (@(posedge clk) disable iff (rst)
        tx_en && host_tx_push && fifo_stat[7] |=> irq_stat[3]); // R7

    AST_RX_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
        rx_en && eng_rx_push && fifo_stat[23] && !host_rx_pop && !reg_we
        |=> $stable(fifo_stat[22:16])); // R7

    AST_RX_UND_ZERO: assert property (@(posedge clk) disable iff (rst)
        host_rx_pop && fifo_stat[24] |-> host_rx_data == 8'h00); // R8

    AST_TX_DIS_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> fifo_stat[8]); // R2

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        irq_stat == 7'h00 |-> !irq); // R11

endmodule

bind dual_fifo_irq dfifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .reg_we(reg_we),
    .host_tx_push(host_tx_push), .host_rx_pop(host_rx_pop),
    .eng_rx_push(eng_rx_push), .host_rx_data(host_rx_data),
    .fifo_stat(fifo_stat), .irq_stat(irq_stat), .irq(irq),
    .tx_en(ctl_q.tx_en), .rx_en(ctl_q.rx_en)
);

// File: tb/dual_fifo_irq_tb.sv
module dual_fifo_irq_tb_top;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        host_tx_push = 1'b0;
    logic [7:0]  host_tx_data = '0;
    logic        host_rx_pop = 1'b0;
    logic [7:0]  host_rx_data;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic [31:0] fifo_stat;
    logic [6:0]  irq_stat;
    logic        irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dual_fifo_irq #(.DEPTH(D), .TRAIL_W(4)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .fifo_stat(fifo_stat), .irq_stat(irq_stat), .irq(irq)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        cyc();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic tx_push(input logic [7:0] b);
        host_tx_push = 1'b1; host_tx_data = b;
        cyc();
        host_tx_push = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        eng_rx_push = 1'b1; eng_rx_data = b;
        cyc();
        eng_rx_push = 1'b0;
    endtask

    task automatic tx_pop(input string req, input logic [7:0] exp);
        eng_tx_pop = 1'b1;
        #1 chk(req, {24'h0, eng_tx_data}, {24'h0, exp});
        cyc();
        eng_tx_pop = 1'b0;
    endtask

    task automatic rx_pop(input string req, input logic [7:0] exp);
        host_rx_pop = 1'b1;
        #1 chk(req, {24'h0, host_rx_data}, {24'h0, exp});
        cyc();
        host_rx_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk("R1 status", fifo_stat, 32'h0100_0100);
        chk("R1 pending", {25'h0, irq_stat}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 disabled FIFOs ignore traffic
        tx_push(8'hA5);
        chk("R2 disabled tx push", fifo_stat, 32'h0100_0100);
        rx_push(8'h5A);
        chk("R2 disabled rx push", fifo_stat, 32'h0100_0100);
        tx_pop("R2 disabled tx pop data", 8'h00);
        rx_pop("R2 disabled rx pop data", 8'h00);
        chk("R2 no flags", {25'h0, irq_stat}, 32'h0);

        // R5 sweep of transmit threshold versus level
        for (int t = 0; t <= D; t++) begin
            wr(2'd0, 32'h0);
            wr(2'd0, 32'h2 | (t << 16));
            for (int l = 0; l <= D; l++) begin
                wr(2'd2, 32'h1);
                chk("R5 almost-empty", {31'h0, irq_stat[0]}, {31'h0, (l <= t)});
                chk("R3 tx level", {25'h0, fifo_stat[6:0]}, l);
                chk("R4 tx full/empty", {30'h0, fifo_stat[7], fifo_stat[8]},
                    {30'h0, (l == D), (l == 0)});
                if (l < D) tx_push(8'(t * 16 + l));
            end
        end
        // R7 transmit overrun, contents kept
        tx_push(8'hEE);
        chk("R7 tx overrun flag", {31'h0, irq_stat[3]}, 32'h1);
        chk("R7 tx level kept", {25'h0, fifo_stat[6:0]}, D);
        for (int i = 0; i < D; i++) tx_pop("R3 tx order", 8'(D * 16 + i));
        // R8 transmit underrun
        tx_pop("R8 tx underrun data", 8'h00);
        chk("R8 tx underrun flag", {31'h0, irq_stat[2]}, 32'h1);

        // R6 sweep of receive threshold versus level
        for (int t = 1; t <= D; t++) begin
            wr(2'd0, 32'h0);
            wr(2'd0, 32'h1 | (t << 4));
            for (int l = 0; l <= D; l++) begin
                wr(2'd2, 32'h2);
                chk("R6 almost-full", {31'h0, irq_stat[1]}, {31'h0, (l >= t)});
                chk("R3 rx level", {25'h0, fifo_stat[22:16]}, l);
                chk("R4 rx full/empty", {30'h0, fifo_stat[23], fifo_stat[24]},
                    {30'h0, (l == D), (l == 0)});
                if (l < D) rx_push(8'(8'h80 + t * 16 + l));
            end
        end
        rx_push(8'h11);
        chk("R7 rx overrun flag", {31'h0, irq_stat[5]}, 32'h1);
        chk("R7 rx level kept", {25'h0, fifo_stat[22:16]}, D);
        for (int i = 0; i < D; i++) rx_pop("R3 rx order", 8'(8'h80 + D * 16 + i));
        rx_pop("R8 rx underrun data", 8'h00);
        chk("R8 rx underrun flag", {31'h0, irq_stat[4]}, 32'h1);

        // R10 selective clear
        wr(2'd2, 32'h8);
        chk("R10 selective clear", {28'h0, irq_stat[5:2]}, 32'hD);

        // R11 masking
        wr(2'd1, 32'h8);
        chk("R11 masked off", {31'h0, irq}, 32'h0);
        wr(2'd1, 32'h4);
        chk("R11 masked on", {31'h0, irq}, 32'h1);
        wr(2'd1, 32'h0);
        chk("R11 mask cleared", {31'h0, irq}, 32'h0);

        // R9 trailing timeout for every limit
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h1 | (4 << 4));
        for (int lim = 0; lim < 16; lim++) begin
            wr(2'd3, lim);
            wr(2'd2, 32'h40);
            rx_push(8'(lim));
            chk("R9 trailing after push", {31'h0, irq_stat[6]}, 32'h0);
            for (int j = 1; j <= lim; j++) begin
                cyc();
                chk("R9 trailing early", {31'h0, irq_stat[6]}, 32'h0);
            end
            cyc();
            chk("R9 trailing fires", {31'h0, irq_stat[6]}, 32'h1);
            rx_pop("R9 trailing data", 8'(lim));
            wr(2'd2, 32'h40);
        end
        // R9 activity restarts the wait
        wr(2'd3, 32'd5);
        rx_push(8'h21);
        repeat (3) cyc();
        rx_push(8'h22);
        for (int j = 1; j <= 5; j++) begin
            cyc();
            chk("R9 restart early", {31'h0, irq_stat[6]}, 32'h0);
        end
        cyc();
        chk("R9 restart fires", {31'h0, irq_stat[6]}, 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule